// File: doc/BRIEF.md
# Dual-Slot Decode Pairing Controller

This block sits between a pre-decoded instruction window and two instruction decoders. On each clock it examines the first two descriptors in the window. Each descriptor carries a byte length, an instruction class, a requested decode kind and the number of micro-operations the instruction expands to. From these it chooses one outcome for the cycle:

- two short instructions decoded together;
- a single short, long or vectored instruction;
- a prefix-absorption cycle;
- a stall while microcode ROM continues a vectored instruction.

It reports how many descriptors were consumed, so the fetch window can shift by exactly that amount. It also reports which decoder slots carry a decoded instruction, how many micro-operations leave this cycle, and how many accumulated prefixes belong to the decoded instruction.

Prefix bytes are not decoded. They are counted in a small saturating accumulator and handed to the next instruction that decodes. The ROM is modelled only as a counter of outstanding micro-operations, drained at one group per clock. While it runs, the window is frozen.

Top module: `decpair_top`

## Requirements
- R1: After reset, with an empty window, take=0, mode=0, slotValid=0, uopCount=0, pfxApplied=0 and romBusy=0.
- R2: A descriptor counts as short only when its kind is short (kind 0), its length is at most 7 bytes and it yields 1 or 2 micro-operations. Any other non-vectored descriptor of at most 11 bytes and 1 to 4 micro-operations counts as long. Everything else counts as vectored.
- R3: Two short instructions decode together with take=2, mode=1, slotValid=2'b11 and uopCount equal to the sum of both counts.
- R4: A long instruction in slot 0 decodes alone with take=1, mode=2, slotValid=2'b01 and its own micro-operation count.
- R5: A vectored instruction in slot 0 decodes alone with mode=3 and emits min(n,4) micro-operations. The rest of its n are then emitted at up to 4 per clock with mode=4 and romBusy=1. During those cycles take=0 and slotValid=0, whatever the window holds.
- R6: Pairing requires slot 1 to be integer class (class 0), or an escape byte. Integer, MMX (class 1) or floating-point (class 2) may sit in slot 0. An MMX or floating-point descriptor in slot 1 never pairs.
- R7: An instruction in slot 0 followed by a prefix (class 3) decodes alone with take=2. The prefix becomes the only accumulated prefix. The decoded instruction reports in pfxApplied the prefixes accumulated before it.
- R8: A prefix followed by a prefix consumes only the first (take=1, mode=5, slotValid=0) and adds it to the accumulator.
- R9: A prefix followed by an instruction, when a prefix is already accumulated, consumes only the prefix (take=1, mode=5). The instruction decodes on the next cycle with the full count.
- R10: A prefix followed by a short instruction, with no prefix accumulated, consumes both: slotValid=2'b10, mode=1, take=2, pfxApplied=1.
- R11: A class-3 descriptor with its escape flag set is not a prefix. It decodes as an integer instruction and may pair.
- R12: uopCount never exceeds 4, take never exceeds the number of valid window entries, and an empty window gives take=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| winValid | input | 2 | Valid flags of window entries 0 and 1 (entry 1 only with entry 0) |
| s0Len | input | 4 | Slot 0 length in bytes |
| s0Cls | input | 2 | Slot 0 class: 0 integer, 1 MMX, 2 floating-point, 3 prefix |
| s0Kind | input | 2 | Slot 0 requested decode: 0 short, 1 long, 2 vectored |
| s0Uops | input | 6 | Slot 0 micro-operation count |
| s0Esc | input | 1 | Slot 0 is an escape byte |
| s1Len | input | 4 | Slot 1 length in bytes |
| s1Cls | input | 2 | Slot 1 class |
| s1Kind | input | 2 | Slot 1 requested decode |
| s1Uops | input | 6 | Slot 1 micro-operation count |
| s1Esc | input | 1 | Slot 1 is an escape byte |
| take | output | 2 | Descriptors consumed this cycle |
| mode | output | 3 | 0 none, 1 short, 2 long, 3 vectored, 4 ROM, 5 prefix |
| slotValid | output | 2 | Decoder slots carrying an instruction |
| uopCount | output | 3 | Micro-operations emitted this cycle |
| pfxApplied | output | 2 | Prefixes attached to the decoded instruction |
| romBusy | output | 1 | ROM sequence active |

## Verification
The assertions watch, on every cycle, three properties:

- the four-per-clock micro-operation bound and the consumption bound;
- the freeze of the window while the ROM runs, together with a ROM start always leading to a busy cycle;
- the requirement that every paired slot 1 is integer-like and decoded in short mode.

What the bench's scenarios alone show are the sequences that span cycles: the ROM draining 4 then 2, and prefix counts carried from absorption cycles to a later decode. They also show the demotion of oversize short descriptors, the three-way prefix-then-instruction choice and the escape exemption. A random phase then re-checks the bound, stall and pairing rules against the bench's own short-qualification test.

// File: rtl/decpair_pkg.sv
package decpair_pkg;
  typedef enum logic [1:0] {CLS_INT = 2'd0, CLS_MMX = 2'd1, CLS_FP = 2'd2, CLS_PFX = 2'd3} clsT;
  typedef enum logic [1:0] {KIND_SHORT = 2'd0, KIND_LONG = 2'd1, KIND_VECT = 2'd2} kindT;
  typedef enum logic [2:0] {MD_NONE = 3'd0, MD_SHORT = 3'd1, MD_LONG = 3'd2, MD_VECT = 3'd3,
                            MD_ROM = 3'd4, MD_PFX = 3'd5} modeT;
  typedef enum logic [1:0] {PFX_HOLD = 2'd0, PFX_INC = 2'd1, PFX_CLR = 2'd2, PFX_ONE = 2'd3} pfxOpT;
  typedef struct packed {
    pfxOpT pfxOp;
    logic  romLoad;
  } strobeT;
endpackage

// File: rtl/decpair_classify.sv
module decpair_classify
  import decpair_pkg::*;
#(
  parameter int LEN_W      = 4,
  parameter int UOP_W      = 6,
  parameter int SHORT_LEN  = 7,
  parameter int LONG_LEN   = 11,
  parameter int SHORT_UOPS = 2,
  parameter int GROUP      = 4
) (
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       cls,
  input  logic [1:0]       kind,
  input  logic [UOP_W-1:0] uops,
  input  logic             esc,
  output kindT             effKind,
  output logic             isPfx,
  output logic             intLike
);
  logic fitsShort, fitsLong;

  always_comb begin
    fitsShort = (kind == KIND_SHORT) && (len <= LEN_W'(SHORT_LEN)) &&
                (uops != '0) && (uops <= UOP_W'(SHORT_UOPS));
    fitsLong  = (kind != KIND_VECT) && (len <= LEN_W'(LONG_LEN)) &&
                (uops != '0) && (uops <= UOP_W'(GROUP));
    if (fitsShort)     effKind = KIND_SHORT;
    else if (fitsLong) effKind = KIND_LONG;
    else               effKind = KIND_VECT;
    isPfx   = (cls == CLS_PFX) && !esc;
    intLike = (cls == CLS_INT) || ((cls == CLS_PFX) && esc);
  end
endmodule

// File: rtl/decpair_ctrl.sv
module decpair_ctrl
  import decpair_pkg::*;
#(
  parameter int UOP_W = 6,
  parameter int PFX_W = 2,
  parameter int GROUP = 4,
  localparam int CNT_W = $clog2(GROUP + 1)
) (
  input  logic [1:0]       winValid,
  input  kindT             effKind [2],
  input  logic             isPfx   [2],
  input  logic             intLike [2],
  input  logic [UOP_W-1:0] uops    [2],
  input  logic             romBusy,
  input  logic [CNT_W-1:0] romUops,
  input  logic [PFX_W-1:0] pfxAcc,
  output logic [1:0]       take,
  output modeT             mode,
  output logic [1:0]       slotValid,
  output logic [CNT_W-1:0] uopCount,
  output logic [PFX_W-1:0] pfxApplied,
  output strobeT           strobe,
  output logic [UOP_W-1:0] romInit
);
  logic v0, v1, canPair;

  always_comb begin
    v0 = winValid[0];
    v1 = winValid[1] && winValid[0];
    canPair = v1 && !isPfx[1] && intLike[1] && (effKind[1] == KIND_SHORT);
    take = 2'd0;
    mode = MD_NONE;
    slotValid = 2'b00;
    uopCount = '0;
    pfxApplied = '0;
    strobe = '{pfxOp: PFX_HOLD, romLoad: 1'b0};
    romInit = '0;
    if (romBusy) begin
      mode = MD_ROM;
      uopCount = romUops;
    end else if (v0 && isPfx[0]) begin
      if (v1 && (isPfx[1] || pfxAcc != '0)) begin
        take = 2'd1;
        mode = MD_PFX;
        strobe.pfxOp = PFX_INC;
      end else if (v1 && effKind[1] == KIND_SHORT) begin
        take = 2'd2;
        mode = MD_SHORT;
        slotValid = 2'b10;
        uopCount = CNT_W'(uops[1]);
        pfxApplied = PFX_W'(1);
        strobe.pfxOp = PFX_CLR;
      end else begin
        take = 2'd1;
        mode = MD_PFX;
        strobe.pfxOp = PFX_INC;
      end
    end else if (v0) begin
      pfxApplied = pfxAcc;
      slotValid = 2'b01;
      take = 2'd1;
      strobe.pfxOp = (v1 && isPfx[1]) ? PFX_ONE : PFX_CLR;
      case (effKind[0])
        KIND_VECT: begin
          mode = MD_VECT;
          if (uops[0] > UOP_W'(GROUP)) begin
            uopCount = CNT_W'(GROUP);
            romInit = uops[0] - UOP_W'(GROUP);
            strobe.romLoad = 1'b1;
          end else begin
            uopCount = CNT_W'(uops[0]);
          end
        end
        KIND_LONG: begin
          mode = MD_LONG;
          uopCount = CNT_W'(uops[0]);
        end
        default: begin
          mode = MD_SHORT;
          uopCount = CNT_W'(uops[0]);
          if (effKind[0] == KIND_SHORT && canPair) begin
            take = 2'd2;
            slotValid = 2'b11;
            uopCount = CNT_W'(uops[0]) + CNT_W'(uops[1]);
          end
        end
      endcase
      if (v1 && isPfx[1]) take = 2'd2;
    end
  end
endmodule

// File: rtl/decpair_dp.sv
module decpair_dp
  import decpair_pkg::*;
#(
  parameter int UOP_W = 6,
  parameter int PFX_W = 2,
  parameter int GROUP = 4,
  localparam int CNT_W = $clog2(GROUP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobeT           strobe,
  input  logic [UOP_W-1:0] romInit,
  output logic [PFX_W-1:0] pfxAcc,
  output logic             romBusy,
  output logic [CNT_W-1:0] romUops
);
  logic [UOP_W-1:0] romLeft;

  always_comb begin
    romBusy = (romLeft != '0);
    romUops = (romLeft > UOP_W'(GROUP)) ? CNT_W'(GROUP) : CNT_W'(romLeft);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      romLeft <= '0;
      pfxAcc  <= '0;
    end else begin
      if (strobe.romLoad)  romLeft <= romInit;
      else if (romBusy)    romLeft <= romLeft - UOP_W'(romUops);
      case (strobe.pfxOp)
        PFX_INC: if (pfxAcc != '1) pfxAcc <= pfxAcc + 1'b1;
        PFX_CLR: pfxAcc <= '0;
        PFX_ONE: pfxAcc <= PFX_W'(1);
        default: pfxAcc <= pfxAcc;
      endcase
    end
  end

  // R5: a ROM start is always followed by a busy cycle
  p_rom_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.romLoad |=> romBusy);
  // R5: no ROM restart while one is running
  p_rom_no_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    romBusy |-> !strobe.romLoad);
endmodule

// File: rtl/decpair_top.sv
module decpair_top
  import decpair_pkg::*;
#(
  parameter int LEN_W      = 4,
  parameter int UOP_W      = 6,
  parameter int PFX_W      = 2,
  parameter int SHORT_LEN  = 7,
  parameter int LONG_LEN   = 11,
  parameter int SHORT_UOPS = 2,
  parameter int GROUP      = 4,
  localparam int CNT_W = $clog2(GROUP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       winValid,
  input  logic [LEN_W-1:0] s0Len,
  input  logic [1:0]       s0Cls,
  input  logic [1:0]       s0Kind,
  input  logic [UOP_W-1:0] s0Uops,
  input  logic             s0Esc,
  input  logic [LEN_W-1:0] s1Len,
  input  logic [1:0]       s1Cls,
  input  logic [1:0]       s1Kind,
  input  logic [UOP_W-1:0] s1Uops,
  input  logic             s1Esc,
  output logic [1:0]       take,
  output logic [2:0]       mode,
  output logic [1:0]       slotValid,
  output logic [CNT_W-1:0] uopCount,
  output logic [PFX_W-1:0] pfxApplied,
  output logic             romBusy
);
  logic [LEN_W-1:0] lenA  [2];
  logic [1:0]       clsA  [2];
  logic [1:0]       kindA [2];
  logic [UOP_W-1:0] uopsA [2];
  logic             escA  [2];
  kindT             effKind [2];
  logic             isPfx   [2];
  logic             intLike [2];
  strobeT           strobe;
  logic [UOP_W-1:0] romInit;
  logic [PFX_W-1:0] pfxAcc;
  logic [CNT_W-1:0] romUops;
  modeT             modeE;

  always_comb begin
    lenA[0] = s0Len;   lenA[1] = s1Len;
    clsA[0] = s0Cls;   clsA[1] = s1Cls;
    kindA[0] = s0Kind; kindA[1] = s1Kind;
    uopsA[0] = s0Uops; uopsA[1] = s1Uops;
    escA[0] = s0Esc;   escA[1] = s1Esc;
  end

  for (genvar i = 0; i < 2; i++) begin : g_cls
    decpair_classify #(
      .LEN_W(LEN_W), .UOP_W(UOP_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
      .SHORT_UOPS(SHORT_UOPS), .GROUP(GROUP)
    ) u_cls (
      .len(lenA[i]), .cls(clsA[i]), .kind(kindA[i]), .uops(uopsA[i]), .esc(escA[i]),
      .effKind(effKind[i]), .isPfx(isPfx[i]), .intLike(intLike[i])
    );
  end

  decpair_ctrl #(.UOP_W(UOP_W), .PFX_W(PFX_W), .GROUP(GROUP)) u_ctrl (
    .winValid(winValid), .effKind(effKind), .isPfx(isPfx), .intLike(intLike),
    .uops(uopsA), .romBusy(romBusy), .romUops(romUops), .pfxAcc(pfxAcc),
    .take(take), .mode(modeE), .slotValid(slotValid), .uopCount(uopCount),
    .pfxApplied(pfxApplied), .strobe(strobe), .romInit(romInit)
  );

  decpair_dp #(.UOP_W(UOP_W), .PFX_W(PFX_W), .GROUP(GROUP)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .romInit(romInit),
    .pfxAcc(pfxAcc), .romBusy(romBusy), .romUops(romUops)
  );

  assign mode = modeE;

  // R12: emission bound
  p_uop_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    uopCount <= CNT_W'(GROUP));
  // R12: never consume more than is valid
  p_take_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    take <= 2'($countones(winValid)));
  // R5: frozen window while the ROM drains
  p_rom_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    romBusy |-> (take == 2'd0 && slotValid == 2'b00));
  // R6: slot 1 of a pair is integer-like
  p_pair_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slotValid == 2'b11) |-> (s1Cls == 2'd0 || (s1Cls == 2'd3 && s1Esc)));
  // R3: pairs are short-mode cycles
  p_pair_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slotValid == 2'b11) |-> (mode == 3'd1 && take == 2'd2));
endmodule

// File: tb/decpair_top_test.sv
module decpair_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] winValid = 2'b00;
  logic [3:0] s0Len = '0, s1Len = '0;
  logic [1:0] s0Cls = '0, s1Cls = '0, s0Kind = '0, s1Kind = '0;
  logic [5:0] s0Uops = '0, s1Uops = '0;
  logic s0Esc = 1'b0, s1Esc = 1'b0;
  logic [1:0] take;
  logic [2:0] mode;
  logic [1:0] slotValid;
  logic [2:0] uopCount;
  logic [1:0] pfxApplied;
  logic romBusy;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  typedef struct {
    int tk; int md; int sv; int up; int pa; int bz; string tag;
  } expT;
  expT expQ[$];

  always #5 clk = ~clk;

  decpair_top uut (
    .clk(clk), .rst_n(rst_n), .winValid(winValid),
    .s0Len(s0Len), .s0Cls(s0Cls), .s0Kind(s0Kind), .s0Uops(s0Uops), .s0Esc(s0Esc),
    .s1Len(s1Len), .s1Cls(s1Cls), .s1Kind(s1Kind), .s1Uops(s1Uops), .s1Esc(s1Esc),
    .take(take), .mode(mode), .slotValid(slotValid), .uopCount(uopCount),
    .pfxApplied(pfxApplied), .romBusy(romBusy)
  );

  task automatic apply(input logic [1:0] v,
                       input int l0, input int c0, input int k0, input int u0, input int e0,
                       input int l1, input int c1, input int k1, input int u1, input int e1,
                       input int tk, input int md, input int sv, input int up, input int pa,
                       input int bz, input string tag);
    expT e;
    @(negedge clk);
    winValid = v;
    s0Len = 4'(l0); s0Cls = 2'(c0); s0Kind = 2'(k0); s0Uops = 6'(u0); s0Esc = 1'(e0);
    s1Len = 4'(l1); s1Cls = 2'(c1); s1Kind = 2'(k1); s1Uops = 6'(u1); s1Esc = 1'(e1);
    e = '{tk, md, sv, up, pa, bz, tag};
    expQ.push_back(e);
  endtask

  initial begin : monitor
    expT e;
    forever begin
      @(negedge clk);
      #4;
      if (expQ.size() != 0) begin
        e = expQ.pop_front();
        nCmp++;
        if (take != 2'(e.tk) || mode != 3'(e.md) || slotValid != 2'(e.sv) ||
            uopCount != 3'(e.up) || pfxApplied != 2'(e.pa) || romBusy != 1'(e.bz)) begin
          nBad++;
          $display("FAIL %s actual take=%0d mode=%0d sv=%0d uops=%0d pfx=%0d busy=%0d expected take=%0d mode=%0d sv=%0d uops=%0d pfx=%0d busy=%0d",
                   e.tag, take, mode, slotValid, uopCount, pfxApplied, romBusy,
                   e.tk, e.md, e.sv, e.up, e.pa, e.bz);
        end
      end
    end
  end

  function automatic bit benchShort(input int l, input int k, input int u);
    return (k == 0) && (l <= 7) && (u >= 1) && (u <= 2);
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 / R12: reset state, empty window
    apply(2'b00, 0,0,0,0,0, 0,0,0,0,0, 0,0,0,0,0,0, "R1 R12 reset/empty");
    // R3: two short integers
    apply(2'b11, 3,0,0,1,0, 2,0,0,2,0, 2,1,3,3,0,0, "R3 pair");
    // R6: MMX first, integer second pairs
    apply(2'b11, 3,1,0,1,0, 2,0,0,1,0, 2,1,3,2,0,0, "R6 mmx+int");
    // R6: MMX + MMX never pairs
    apply(2'b11, 3,1,0,1,0, 3,1,0,1,0, 1,1,1,1,0,0, "R6 mmx+mmx");
    // R6: integer + FP never pairs
    apply(2'b11, 3,0,0,1,0, 3,2,0,1,0, 1,1,1,1,0,0, "R6 int+fp");
    // R2: short too long in bytes -> long
    apply(2'b11, 9,0,0,1,0, 2,0,0,1,0, 1,2,1,1,0,0, "R2 len9 demote");
    // R2: short with 3 uops -> long
    apply(2'b01, 3,0,0,3,0, 0,0,0,0,0, 1,2,1,3,0,0, "R2 uops3 demote");
    // R4: long alone
    apply(2'b11, 10,0,1,4,0, 2,0,0,1,0, 1,2,1,4,0,0, "R4 long");
    // R2: long of 13 bytes -> vectored, 2 uops, no ROM
    apply(2'b01, 13,0,1,2,0, 0,0,0,0,0, 1,3,1,2,0,0, "R2 len13 vectored");
    // R5: vectored 10 uops: 4 now, then 4 and 2 from ROM with window frozen
    apply(2'b01, 5,0,2,10,0, 0,0,0,0,0, 1,3,1,4,0,0, "R5 vect start");
    apply(2'b11, 3,0,0,1,0, 3,0,0,1,0, 0,4,0,4,0,1, "R5 rom 1");
    apply(2'b11, 3,0,0,1,0, 3,0,0,1,0, 0,4,0,2,0,1, "R5 rom 2");
    apply(2'b11, 3,0,0,1,0, 3,0,0,1,0, 2,1,3,2,0,0, "R5 after rom");
    // R7: instruction then prefix
    apply(2'b11, 3,0,0,1,0, 1,3,0,1,0, 2,1,1,1,0,0, "R7 inst+pfx");
    // R9: prefix pending, prefix + instruction: only prefix consumed
    apply(2'b11, 1,3,0,1,0, 3,0,0,2,0, 1,5,0,0,0,0, "R9 pfx absorb");
    apply(2'b01, 3,0,0,2,0, 0,0,0,0,0, 1,1,1,2,2,0, "R9 R7 inst gets 2");
    // R8: two prefixes
    apply(2'b11, 1,3,0,1,0, 1,3,0,1,0, 1,5,0,0,0,0, "R8 pfx+pfx");
    apply(2'b11, 1,3,0,1,0, 8,0,1,3,0, 1,5,0,0,0,0, "R9 pfx+long pending");
    apply(2'b01, 8,0,1,3,0, 0,0,0,0,0, 1,2,1,3,2,0, "R8 long gets 2");
    // R10: lone prefix + short
    apply(2'b11, 1,3,0,1,0, 3,0,0,1,0, 2,1,2,1,1,0, "R10 pfx+short");
    // R11: escape descriptors are not prefixes
    apply(2'b11, 1,3,0,1,1, 3,0,0,1,0, 2,1,3,2,0,0, "R11 esc slot0");
    apply(2'b11, 3,0,0,1,0, 1,3,0,1,1, 2,1,3,2,0,0, "R11 esc slot1");
    apply(2'b00, 0,0,0,0,0, 0,0,0,0,0, 0,0,0,0,0,0, "R12 empty");
    while (expQ.size() != 0) @(posedge clk);
    @(posedge clk);
    // random phase: invariants
    for (int n = 0; n < 400; n++) begin
      int vs, l0, c0, k0, u0, e0, l1, c1, k1, u1, e1;
      vs = $urandom % 3;
      l0 = $urandom % 16; c0 = $urandom % 4; k0 = $urandom % 3; u0 = $urandom % 14; e0 = $urandom % 4 == 0;
      l1 = $urandom % 16; c1 = $urandom % 4; k1 = $urandom % 3; u1 = $urandom % 14; e1 = $urandom % 4 == 0;
      @(negedge clk);
      winValid = (vs == 0) ? 2'b00 : (vs == 1) ? 2'b01 : 2'b11;
      s0Len = 4'(l0); s0Cls = 2'(c0); s0Kind = 2'(k0); s0Uops = 6'(u0); s0Esc = 1'(e0);
      s1Len = 4'(l1); s1Cls = 2'(c1); s1Kind = 2'(k1); s1Uops = 6'(u1); s1Esc = 1'(e1);
      #4;
      nCmp++;
      if (uopCount > 3'd4) begin
        nBad++;
        $display("FAIL R12 uop bound actual=%0d expected<=4", uopCount);
      end
      nCmp++;
      if (romBusy && (take != 2'd0 || slotValid != 2'b00)) begin
        nBad++;
        $display("FAIL R5 stall actual take=%0d sv=%0d expected 0/0", take, slotValid);
      end
      nCmp++;
      if (slotValid == 2'b11 &&
          !((c1 == 0 || (c1 == 3 && e1 != 0)) && benchShort(l1, k1, u1) && benchShort(l0, k0, u0))) begin
        nBad++;
        $display("FAIL R6 pairing actual sv=3 cls1=%0d expected no pair", c1);
      end
    end
    done = 1;
    finishRun();
  end
endmodule